// File: doc/BRIEF.md
# Three-Step Motion Search Sequencer

This block steers a coarse-to-fine block-matching search for one macroblock. Starting from a zero displacement, it proposes candidate offsets (u,v) to an external cost engine over a request/acknowledge handshake. It takes back one sum-of-absolute-differences value per candidate and keeps the cheapest point seen so far. After each round it recentres on that point. After the third round it reports the winning displacement and its cost.

A caller sets the half-range of the search window, pulses start, and services the cost requests. Pixel fetch and difference arithmetic live outside the block. Each round looks at a 3x3 grid of points spaced by the current step. The step begins at half the window half-range and halves every round. Points that would leave the window are never requested.

Top module: `tss_search_ctrl`

## Requirements
- R1: A start pulse while idle latches the half-range d and begins a search whose first requested candidate is (0,0). A start pulse while a search is running is ignored.
- R2: Within a round, candidates are taken in this order: the centre first, then the eight surrounding points in raster order. Raster order means rows by increasing v, and within a row by increasing u. Each surrounding point sits at an offset of -step, 0 or +step on each axis.
- R3: The step of the first round is d/2, with a minimum of 1. Each later round uses half the previous step, again with a minimum of 1.
- R4: A search has exactly three rounds. Between rounds, the centre moves to the lowest-cost candidate found so far.
- R5: A candidate with |u| > d or |v| > d is skipped and never presented on the cost interface.
- R6: In the second and third rounds, the centre is not requested again. Its cost carries over from the earlier round.
- R7: A candidate replaces the current best only when its cost is strictly smaller. On equal cost, the earlier candidate stays.
- R8: While a request is raised and not yet acknowledged, the request stays high and the candidate offsets stay unchanged. The cost is taken in the cycle the acknowledge is high.
- R9: Done is high for exactly one cycle, and the motion vector and best cost are valid in that cycle. These result outputs change only in a done cycle, so they hold through the next search until it completes.
- R10: Offsets and the motion vector are signed two's complement, $clog2(DMAX)+2 bits wide. After reset, every output is zero.
- R11: d must be a power of two between 2 and DMAX. The range input is an unsigned binary value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a search (honoured only when idle) |
| range_i | input | $clog2(DMAX)+1 | Window half-range d |
| cost_req_o | output | 1 | Candidate cost request |
| cand_u_o | output | $clog2(DMAX)+2 | Candidate horizontal offset, signed |
| cand_v_o | output | $clog2(DMAX)+2 | Candidate vertical offset, signed |
| cost_ack_i | input | 1 | Cost valid for the current request |
| cost_sad_i | input | SAD_W | Cost of the current candidate |
| done_o | output | 1 | One-cycle search-complete pulse |
| mv_u_o | output | $clog2(DMAX)+2 | Winning horizontal displacement, signed |
| mv_v_o | output | $clog2(DMAX)+2 | Winning vertical displacement, signed |
| best_sad_o | output | SAD_W | Cost of the winning displacement |

## Verification
Assertions check on every cycle that a pending request holds still and that a presented candidate lies inside the window. They also check that done lasts one cycle, that results change only with done, that no request is raised in a done cycle, and that start arrives with a legal range. Only the bench's scenarios can show that the whole candidate sequence is correct. That sequence depends on the skip of the carried centre, the step schedule, the recentring and the tie rule. The bench compares it, together with the final vector and cost, against an arithmetic model. The model runs over target positions that cover the window for every legal range and over several cost shapes, including a flat one.

// File: rtl/tss_pkg.sv
package tss_pkg;
   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_EVAL = 2'd1,
      S_WAIT = 2'd2,
      S_NEXT = 2'd3
   } tss_state_e;

   localparam int TSS_ROUNDS = 3;
   localparam int TSS_SLOTS  = 9;
endpackage

// File: rtl/tss_cand_gen.sv
module tss_cand_gen #(
   parameter int DMAX = 16
) (
   input  logic signed [$clog2(DMAX)+1:0] cen_u_i,
   input  logic signed [$clog2(DMAX)+1:0] cen_v_i,
   input  logic        [$clog2(DMAX):0]   step_i,
   input  logic        [$clog2(DMAX):0]   lim_i,
   input  logic        [3:0]              slot_i,
   output logic signed [$clog2(DMAX)+1:0] cand_u_o,
   output logic signed [$clog2(DMAX)+1:0] cand_v_o,
   output logic                           inside_o
);
   localparam int RNG_W = $clog2(DMAX) + 1;
   localparam int OFS_W = $clog2(DMAX) + 2;
   localparam int EXT_W = OFS_W + 1;

   logic [3:0]              grid_pos;
   logic [1:0]              col, row;
   logic signed [EXT_W-1:0] st_x, lim_x, cu_x, cv_x, u_x, v_x;

   // slot 0 is the centre (grid cell 4); slots 1..8 walk the other cells in raster order
   always_comb begin
      if (slot_i == 4'd0)      grid_pos = 4'd4;
      else if (slot_i <= 4'd4) grid_pos = slot_i - 4'd1;
      else                     grid_pos = slot_i;
      col = 2'(grid_pos % 4'd3);
      row = 2'(grid_pos / 4'd3);
   end

   assign st_x  = $signed({{(EXT_W-RNG_W){1'b0}}, step_i});
   assign lim_x = $signed({{(EXT_W-RNG_W){1'b0}}, lim_i});
   assign cu_x  = $signed({cen_u_i[OFS_W-1], cen_u_i});
   assign cv_x  = $signed({cen_v_i[OFS_W-1], cen_v_i});

   always_comb begin
      case (col)
         2'd0:    u_x = cu_x - st_x;
         2'd1:    u_x = cu_x;
         default: u_x = cu_x + st_x;
      endcase
      case (row)
         2'd0:    v_x = cv_x - st_x;
         2'd1:    v_x = cv_x;
         default: v_x = cv_x + st_x;
      endcase
   end

   assign inside_o = (u_x <= lim_x) && (u_x >= -lim_x) &&
                     (v_x <= lim_x) && (v_x >= -lim_x);
   assign cand_u_o = u_x[OFS_W-1:0];
   assign cand_v_o = v_x[OFS_W-1:0];
endmodule

// File: rtl/tss_best_track.sv
module tss_best_track #(
   parameter int DMAX  = 16,
   parameter int SAD_W = 16
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           load_i,
   input  logic                           offer_i,
   input  logic        [SAD_W-1:0]        sad_i,
   input  logic signed [$clog2(DMAX)+1:0] u_i,
   input  logic signed [$clog2(DMAX)+1:0] v_i,
   output logic        [SAD_W-1:0]        best_sad_o,
   output logic signed [$clog2(DMAX)+1:0] best_u_o,
   output logic signed [$clog2(DMAX)+1:0] best_v_o
);
   logic take;

   // strict compare keeps the earlier candidate on a tie (R7)
   assign take = load_i | (offer_i & (sad_i < best_sad_o));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         best_sad_o <= '0;
         best_u_o   <= '0;
         best_v_o   <= '0;
      end else if (take) begin
         best_sad_o <= sad_i;
         best_u_o   <= u_i;
         best_v_o   <= v_i;
      end
   end

   a_r7_no_worse : assert property (@(posedge clk) disable iff (!rst_n)
      (offer_i && !load_i) |=> (best_sad_o <= $past(best_sad_o)));
endmodule

// File: rtl/tss_search_ctrl.sv
module tss_search_ctrl
   import tss_pkg::*;
#(
   parameter int DMAX  = 16,
   parameter int SAD_W = 16
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           start_i,
   input  logic        [$clog2(DMAX):0]   range_i,
   output logic                           cost_req_o,
   output logic signed [$clog2(DMAX)+1:0] cand_u_o,
   output logic signed [$clog2(DMAX)+1:0] cand_v_o,
   input  logic                           cost_ack_i,
   input  logic        [SAD_W-1:0]        cost_sad_i,
   output logic                           done_o,
   output logic signed [$clog2(DMAX)+1:0] mv_u_o,
   output logic signed [$clog2(DMAX)+1:0] mv_v_o,
   output logic        [SAD_W-1:0]        best_sad_o
);
   localparam int RNG_W = $clog2(DMAX) + 1;
   localparam int OFS_W = $clog2(DMAX) + 2;
   localparam logic [1:0] LAST_ROUND = 2'(TSS_ROUNDS - 1);
   localparam logic [3:0] LAST_SLOT  = 4'(TSS_SLOTS - 1);

   generate
      if (DMAX < 2 || (DMAX & (DMAX - 1)) != 0) begin : g_bad_dmax
         $error("DMAX must be a power of two of at least 2");
      end
      if (SAD_W < 1) begin : g_bad_sadw
         $error("SAD_W must be positive");
      end
   endgenerate

   tss_state_e              state_q;
   logic [3:0]              slot_q;
   logic [1:0]              round_q;
   logic [RNG_W-1:0]        step_q, lim_q, init_step;
   logic signed [OFS_W-1:0] cen_u_q, cen_v_q;
   logic signed [OFS_W-1:0] gen_u, gen_v, trk_u, trk_v;
   logic                    gen_inside, skip_slot, acked, first_cost;
   logic [SAD_W-1:0]        trk_sad;

   tss_cand_gen #(.DMAX(DMAX)) u_gen (
      .cen_u_i  (cen_u_q),
      .cen_v_i  (cen_v_q),
      .step_i   (step_q),
      .lim_i    (lim_q),
      .slot_i   (slot_q),
      .cand_u_o (gen_u),
      .cand_v_o (gen_v),
      .inside_o (gen_inside)
   );

   assign acked      = (state_q == S_WAIT) && cost_ack_i;
   assign first_cost = (round_q == 2'd0) && (slot_q == 4'd0);

   tss_best_track #(.DMAX(DMAX), .SAD_W(SAD_W)) u_best (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (acked && first_cost),
      .offer_i    (acked),
      .sad_i      (cost_sad_i),
      .u_i        (gen_u),
      .v_i        (gen_v),
      .best_sad_o (trk_sad),
      .best_u_o   (trk_u),
      .best_v_o   (trk_v)
   );

   // the carried centre (later rounds) and points off the window are passed over
   assign skip_slot = ((slot_q == 4'd0) && (round_q != 2'd0)) || !gen_inside;
   assign init_step = ((range_i >> 1) == '0) ? RNG_W'(1) : (range_i >> 1);

   assign cost_req_o = (state_q == S_WAIT);
   assign cand_u_o   = gen_u;
   assign cand_v_o   = gen_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= S_IDLE;
         slot_q     <= '0;
         round_q    <= '0;
         step_q     <= RNG_W'(1);
         lim_q      <= '0;
         cen_u_q    <= '0;
         cen_v_q    <= '0;
         done_o     <= 1'b0;
         mv_u_o     <= '0;
         mv_v_o     <= '0;
         best_sad_o <= '0;
      end else begin
         done_o <= 1'b0;
         unique case (state_q)
            S_IDLE: begin
               if (start_i) begin
                  lim_q   <= range_i;
                  step_q  <= init_step;
                  cen_u_q <= '0;
                  cen_v_q <= '0;
                  slot_q  <= '0;
                  round_q <= '0;
                  state_q <= S_EVAL;
               end
            end
            S_EVAL: begin
               if (!skip_slot) begin
                  state_q <= S_WAIT;
               end else if (slot_q == LAST_SLOT) begin
                  state_q <= S_NEXT;
               end else begin
                  slot_q <= slot_q + 4'd1;
               end
            end
            S_WAIT: begin
               if (cost_ack_i) begin
                  if (slot_q == LAST_SLOT) begin
                     state_q <= S_NEXT;
                  end else begin
                     slot_q  <= slot_q + 4'd1;
                     state_q <= S_EVAL;
                  end
               end
            end
            S_NEXT: begin
               cen_u_q <= trk_u;
               cen_v_q <= trk_v;
               if (round_q == LAST_ROUND) begin
                  done_o     <= 1'b1;
                  mv_u_o     <= trk_u;
                  mv_v_o     <= trk_v;
                  best_sad_o <= trk_sad;
                  state_q    <= S_IDLE;
               end else begin
                  round_q <= round_q + 2'd1;
                  step_q  <= (step_q > RNG_W'(1)) ? (step_q >> 1) : RNG_W'(1);
                  slot_q  <= '0;
                  state_q <= S_EVAL;
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   // ---------------- assertions ----------------
   a_r8_req_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (cost_req_o && !cost_ack_i) |=>
         (cost_req_o && $stable(cand_u_o) && $stable(cand_v_o)));

   a_r5_in_window : assert property (@(posedge clk) disable iff (!rst_n)
      cost_req_o |-> ((cand_u_o <= $signed({1'b0, lim_q})) &&
                      (cand_u_o >= -$signed({1'b0, lim_q})) &&
                      (cand_v_o <= $signed({1'b0, lim_q})) &&
                      (cand_v_o >= -$signed({1'b0, lim_q}))));

   a_r9_done_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r9_result_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(mv_u_o) && $stable(mv_v_o) && $stable(best_sad_o)));

   a_r4_quiet_done : assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !cost_req_o);

   a_r11_range_legal : assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && state_q == S_IDLE) |->
         ($onehot(range_i) && range_i >= RNG_W'(2) && range_i <= RNG_W'(DMAX)));
endmodule

// File: tb/tb_tss_search_ctrl.sv
`timescale 1ns/1ps
module tb_tss_search_ctrl;
   localparam int DMAX  = 16;
   localparam int SAD_W = 16;
   localparam int RNG_W = $clog2(DMAX) + 1;
   localparam int OFS_W = $clog2(DMAX) + 2;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    start = 1'b0;
   logic [RNG_W-1:0]        rng_in = '0;
   logic                    cost_req;
   logic signed [OFS_W-1:0] cand_u, cand_v;
   logic                    cost_ack = 1'b0;
   logic [SAD_W-1:0]        cost_sad = '0;
   logic                    done;
   logic signed [OFS_W-1:0] mv_u, mv_v;
   logic [SAD_W-1:0]        best_sad;

   int errors = 0;
   int checks = 0;
   int cycles = 0;

   int cur_d = 2, cur_mode = 0, cur_tu = 0, cur_tv = 0;
   int exp_u [0:31];
   int exp_v [0:31];
   int obs_u [0:31];
   int obs_v [0:31];
   int nobs = 0;
   int lfsr = 32'h1d3;

   always #4 clk = ~clk;

   tss_search_ctrl #(.DMAX(DMAX), .SAD_W(SAD_W)) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start),
      .range_i    (rng_in),
      .cost_req_o (cost_req),
      .cand_u_o   (cand_u),
      .cand_v_o   (cand_v),
      .cost_ack_i (cost_ack),
      .cost_sad_i (cost_sad),
      .done_o     (done),
      .mv_u_o     (mv_u),
      .mv_v_o     (mv_v),
      .best_sad_o (best_sad)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   function automatic int iabs(input int x);
      return (x < 0) ? -x : x;
   endfunction

   function automatic int cost_fn(input int mode, input int tu, input int tv,
                                  input int u, input int v);
      int du = iabs(u - tu);
      int dv = iabs(v - tv);
      if (mode == 0)      return du + dv;
      else if (mode == 1) return 40;
      else                return 3 * du + dv + 7;
   endfunction

   // arithmetic model of the search, written from the requirements
   task automatic model(input int d, input int mode, input int tu, input int tv,
                        output int eu, output int ev, output int es, output int en);
      int cu = 0, cv = 0, s, bs, bu = 0, bv = 0;
      s  = (d / 2 < 1) ? 1 : d / 2;                          // R3
      bs = cost_fn(mode, tu, tv, 0, 0);
      exp_u[0] = 0; exp_v[0] = 0; en = 1;                    // R1
      for (int r = 0; r < 3; r++) begin                      // R4
         for (int k = 0; k < 9; k++) begin                   // R2 raster
            int u, v, c;
            u = cu + (k % 3 - 1) * s;
            v = cv + (k / 3 - 1) * s;
            if (k == 4) continue;                            // R6 centre carried
            if (iabs(u) > d || iabs(v) > d) continue;        // R5
            exp_u[en] = u; exp_v[en] = v; en++;
            c = cost_fn(mode, tu, tv, u, v);
            if (c < bs) begin bs = c; bu = u; bv = v; end    // R7 strict
         end
         cu = bu; cv = bv;
         s = (s / 2 < 1) ? 1 : s / 2;
      end
      eu = bu; ev = bv; es = bs;
   endtask

   // cost engine with pseudo-random acknowledge latency
   initial begin : responder
      bit holding = 0;
      int hu = 0, hv = 0, wcnt = 0;
      forever begin
         @(negedge clk);
         if (cost_ack) begin
            cost_ack = 1'b0;
         end else if (cost_req) begin
            if (!holding) begin
               holding = 1; hu = cand_u; hv = cand_v;
               lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hb400 : 0);
               wcnt = lfsr % 4;
            end else begin
               chk(cand_u == hu && cand_v == hv, "R8", "candidate moved while pending",
                   cand_u * 100 + cand_v, hu * 100 + hv);
            end
            if (wcnt == 0) begin
               chk(iabs(cand_u) <= cur_d && iabs(cand_v) <= cur_d, "R5",
                   "request outside window", iabs(cand_u) + iabs(cand_v), cur_d);
               cost_sad = SAD_W'(cost_fn(cur_mode, cur_tu, cur_tv, cand_u, cand_v));
               cost_ack = 1'b1;
               if (nobs < 32) begin obs_u[nobs] = cand_u; obs_v[nobs] = cand_v; end
               nobs++;
               holding = 0;
            end else begin
               wcnt--;
            end
         end
      end
   end

   task automatic run_search(input int d, input int mode, input int tu, input int tv,
                             input bit poke);
      int eu, ev, es, en, n;
      int pu = mv_u, pv = mv_v, ps = best_sad;
      bit seq_ok;
      model(d, mode, tu, tv, eu, ev, es, en);
      cur_d = d; cur_mode = mode; cur_tu = tu; cur_tv = tv; nobs = 0;
      @(negedge clk); start = 1'b1; rng_in = RNG_W'(d);
      @(negedge clk); start = 1'b0;
      chk(mv_u == pu && mv_v == pv && best_sad == ps, "R9", "result changed at start",
          mv_u * 100 + mv_v, pu * 100 + pv);
      if (poke) begin
         repeat (6) @(negedge clk);
         start = 1'b1; rng_in = RNG_W'(2);
         @(negedge clk); start = 1'b0;
      end
      n = 0;
      while (!done && n < 4000) begin @(negedge clk); n++; end
      chk(done == 1'b1, "R4", "done never arrived", n, 0);
      chk(mv_u == eu, poke ? "R1" : "R4", "mv_u", mv_u, eu);
      chk(mv_v == ev, poke ? "R1" : "R4", "mv_v", mv_v, ev);
      chk(best_sad == es, "R7", "best cost", best_sad, es);
      chk(nobs == en, "R6", "request count", nobs, en);
      seq_ok = (nobs == en);
      for (int i = 0; i < 32; i++)
         if (seq_ok && i < en && (obs_u[i] != exp_u[i] || obs_v[i] != exp_v[i]))
            seq_ok = 0;
      chk(seq_ok, "R2", "candidate sequence (R3 step, R1 first point)", nobs, en);
      @(negedge clk);
      chk(done == 1'b0, "R9", "done wider than one cycle", done, 0);
      chk(mv_u == eu && mv_v == ev, "R9", "result not held", mv_u * 100 + mv_v,
          eu * 100 + ev);
   endtask

   initial begin : watchdog
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
         end
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(done == 0 && cost_req == 0, "R10", "control outputs at reset", done + cost_req, 0);
      chk(mv_u == 0 && mv_v == 0 && best_sad == 0, "R10", "results at reset",
          mv_u * 100 + mv_v + best_sad, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(cost_req == 0, "R1", "request without start", cost_req, 0);

      // R11 legal ranges; L1 cost, targets across the window (ties exercise R7)
      for (int e = 1; e <= 4; e++) begin
         int d, st;
         d  = 1 << e;
         st = (d / 4 < 1) ? 1 : d / 4;
         for (int tu = -d; tu <= d; tu += st)
            for (int tv = -d; tv <= d; tv += st)
               run_search(d, 0, tu, tv, 0);
      end
      // flat cost: every tie keeps the origin (R7)
      for (int e = 1; e <= 4; e++) run_search(1 << e, 1, 0, 0, 0);
      // weighted cost, targets at corners and beyond window (R5)
      for (int e = 1; e <= 4; e++) begin
         int d;
         d = 1 << e;
         run_search(d, 2, d, -d, 0);
         run_search(d, 2, -d - 5, d + 3, 0);
         run_search(d, 2, 1, -1, 0);
      end
      // start while busy is ignored (R1)
      run_search(16, 0, 5, -7, 1);
      run_search(8, 2, -3, 6, 1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule